// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes 16-bit stereo PCM from a three-wire serial link (a bit clock, a channel-select clock that runs at the sample rate, and a serial data line) and turns it into parallel left/right sample pairs in the system clock domain. All three wires are brought into the system clock domain through a chain of synchronizing flops. The block then finds the rising edges of the bit clock and the transitions of the channel clock by comparing successive sampled values. The system clock must therefore run several times faster than the bit clock.

Within each half-frame the first 16 bits are shifted in, most significant bit first. The bit clock may run anywhere between 32 and 64 times the sample rate, so a half-frame can carry up to 32 bit slots, and any slot after the sixteenth is dropped. A transition of the channel clock closes the current word and routes it by the level the channel clock had during that word. Once a right word closes and a left word is waiting, both words appear together on the parallel outputs with a one-cycle valid strobe. Whatever arrives before the first channel transition after reset is thrown away.

Top module: `serial_audio_rx`

## Requirements
- R1: Serial data is sampled on rising bit-clock edges and assembled most significant bit first. A channel-clock transition closes the current word and restarts bit assembly from empty.
- R2: A word received while the channel clock was high is a left sample. A word received while it was low is a right sample.
- R3: Only the first 16 bits after a channel-clock transition form the word. Up to 16 further bit slots in the same half-frame (bit clock up to 64fs) do not change the emitted sample.
- R4: Samples pass through unchanged as 16-bit two's complement values: 16'h7FFF (positive full scale), 16'h8000 (negative full scale) and 16'h0000 (mid-scale) appear on the outputs exactly as sent.
- R5: When a right word closes and a left word from the preceding half-frame is pending, `left_o` and `right_o` are updated together and `valid_o` is high for exactly one system clock cycle. Each such pair is emitted once, in arrival order.
- R6: Between valid strobes, `left_o` and `right_o` hold their values.
- R7: The half-frame that is in progress when reset is released is discarded. A right word that closes with no pending left word is not emitted.
- R8: While `rst` is high and after it is released, `valid_o` is low and both sample outputs read 16'h0000 until the first pair is emitted.
- R9: The channel-clock level present when reset is released is not treated as a transition, whether that level is high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic is synchronous to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial bit clock, asynchronous to clk |
| ws_i | input | 1 | Channel-select clock: high for left, low for right |
| sd_i | input | 1 | Serial data, MSB first, two's complement |
| left_o | output | 16 | Left sample of the latest pair |
| right_o | output | 16 | Right sample of the latest pair |
| valid_o | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
Four properties are checked on every clock: the valid strobe is never longer than one cycle, the outputs hold still between strobes, the bit counter never passes the word width, and a channel transition always empties the bit counter. Several behaviours can only be shown by the bench's scenarios, which a behavioural model follows frame by frame: the routing of words to the left or right output, that extra bit slots at 24 and 32 bits per half-frame are ignored, that the full-scale codes pass through intact, and that the partial first half-frame and an orphan right word are dropped after resets taken with either channel-clock level.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  localparam int SYNC_STAGES_DEFAULT = 2;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sar_edge.sv
module sar_edge
  import serial_audio_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sck_s_i,
  input  logic  ws_s_i,
  input  logic  sd_s_i,
  output logic  sck_rise_o,
  output logic  ws_edge_o,
  output chan_e ws_ended_o,
  output logic  sd_o
);

  localparam int WARM_CYC = STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_CYC + 1);

  logic [WARM_W-1:0] warm_q;
  logic              warm_done;
  logic              sck_d, ws_d, sd_d;

  assign warm_done = (warm_q == WARM_W'(WARM_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q <= '0;
      sck_d  <= 1'b0;
      ws_d   <= 1'b0;
      sd_d   <= 1'b0;
    end else begin
      if (!warm_done) warm_q <= warm_q + 1'b1;
      sck_d <= sck_s_i;
      ws_d  <= ws_s_i;
      sd_d  <= sd_s_i;
    end
  end

  assign sck_rise_o = warm_done & sck_s_i & ~sck_d;
  assign ws_edge_o  = warm_done & (ws_s_i ^ ws_d);
  assign ws_ended_o = chan_e'(ws_d);
  assign sd_o       = sd_s_i;

  logic unused_sd;
  assign unused_sd = sd_d;

endmodule

// File: rtl/sar_shift.sv
module sar_shift
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise_i,
  input  logic              ws_edge_i,
  input  chan_e             ws_ended_i,
  input  logic              sd_i,
  output logic              word_stb_o,
  output chan_e             word_chan_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q      <= '0;
      cnt_q       <= '0;
      armed_q     <= 1'b0;
      word_stb_o  <= 1'b0;
      word_chan_o <= CH_RIGHT;
      word_o      <= '0;
    end else begin
      word_stb_o <= 1'b0;
      if (ws_edge_i) begin
        if (armed_q) begin
          word_stb_o  <= 1'b1;
          word_chan_o <= ws_ended_i;
          word_o      <= sreg_q;
        end
        armed_q <= 1'b1;
        sreg_q  <= '0;
        cnt_q   <= '0;
      end else if (sck_rise_i && (cnt_q < CNT_W'(WORD_W))) begin
        sreg_q <= {sreg_q[WORD_W-2:0], sd_i};
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W)); // R3

  AST_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    ws_edge_i |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = SYNC_STAGES_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int LINES = 3;

  logic [LINES-1:0]  raw, synced;
  logic              sck_rise, ws_edge, sd_al;
  chan_e             ws_ended;
  logic              word_stb;
  chan_e             word_chan;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] left_hold_q;
  logic              have_left_q;

  assign raw = {sck_i, ws_i, sd_i};

  sar_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced)
  );

  sar_edge #(.STAGES(SYNC_STAGES)) i_edge (
    .clk        (clk),
    .rst        (rst),
    .sck_s_i    (synced[2]),
    .ws_s_i     (synced[1]),
    .sd_s_i     (synced[0]),
    .sck_rise_o (sck_rise),
    .ws_edge_o  (ws_edge),
    .ws_ended_o (ws_ended),
    .sd_o       (sd_al)
  );

  sar_shift #(.WORD_W(WORD_W)) i_shift (
    .clk         (clk),
    .rst         (rst),
    .sck_rise_i  (sck_rise),
    .ws_edge_i   (ws_edge),
    .ws_ended_i  (ws_ended),
    .sd_i        (sd_al),
    .word_stb_o  (word_stb),
    .word_chan_o (word_chan),
    .word_o      (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_stb) begin
        if (word_chan == CH_LEFT) begin
          left_hold_q <= word;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= left_hold_q;
          right_o     <= word;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R6

endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        ws  = 1'b0;
  logic        sd  = 1'b0;
  logic [15:0] left_o, right_o;
  logic        valid_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;
  bit live = 1'b0;

  // behavioural model state
  logic [31:0] exp_q[$];
  logic [15:0] cur_word_m;
  int          cur_bits_m;
  bit          armed_m, have_left_m;
  logic [15:0] lhold_m;
  logic [15:0] cur_l, cur_r;

  always #10 clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst(rst), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic fail(input string req, input logic [31:0] act, input logic [31:0] exp);
    nerr++;
    $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      nvec++;
      if (valid_o) begin
        if (exp_q.size() == 0) fail("R5/R7 unexpected pair", {left_o, right_o}, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if ({left_o, right_o} !== e) fail("R1/R2/R3/R4 pair value", {left_o, right_o}, e);
          cur_l = e[31:16];
          cur_r = e[15:0];
        end
      end else if ({left_o, right_o} !== {cur_l, cur_r}) begin
        fail("R6 hold", {left_o, right_o}, {cur_l, cur_r});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_edge();
    if (armed_m) begin
      if (ws) begin
        lhold_m = cur_word_m;
        have_left_m = 1'b1;
      end else if (have_left_m) begin
        exp_q.push_back({lhold_m, cur_word_m});
        have_left_m = 1'b0;
      end
    end
    armed_m = 1'b1;
  endtask

  task automatic set_ws(input logic v);
    if (v != ws) begin
      model_edge();
      ws = v;
      cur_word_m = '0;
      cur_bits_m = 0;
    end
  endtask

  task automatic send_bit(input logic b);
    sd = b;
    wait_clk(4);
    sck = 1'b1;
    if (cur_bits_m < 16) begin
      cur_word_m = {cur_word_m[14:0], b};
      cur_bits_m++;
    end
    wait_clk(4);
    sck = 1'b0;
  endtask

  task automatic send_half(input logic chan, input logic [15:0] w, input int slots);
    set_ws(chan);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
    for (int i = 16; i < slots; i++) send_bit(1'($urandom));
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int slots);
    send_half(1'b1, l, slots);
    send_half(1'b0, r, slots);
  endtask

  task automatic do_reset(input logic ws_level);
    live = 1'b0;
    rst = 1'b1;
    ws = ws_level;
    sck = 1'b0;
    sd = 1'b0;
    exp_q.delete();
    armed_m = 1'b0;
    have_left_m = 1'b0;
    cur_word_m = '0;
    cur_bits_m = 0;
    cur_l = '0;
    cur_r = '0;
    wait_clk(5);
    nvec++; // R8 during reset
    if ({valid_o, left_o, right_o} !== 33'h0) fail("R8 reset state", {15'h0, valid_o, left_o}, 32'h0);
    rst = 1'b0;
    live = 1'b1;
    wait_clk(10);
    nvec++; // R8 / R9 after release, no spurious activity
    if ({valid_o, left_o, right_o} !== 33'h0) fail("R8/R9 post-reset", {15'h0, valid_o, left_o}, 32'h0);
  endtask

  task automatic final_drain(input string tag);
    set_ws(~ws);
    wait_clk(30);
    nvec++;
    if (exp_q.size() != 0) fail(tag, exp_q.size(), 0);
  endtask

  initial begin
    // phase A: reset with channel clock low, partial right half discarded (R7, R9)
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'($urandom));
    send_frame(16'h7FFF, 16'h8000, 16);  // R4 full scale, 32fs
    send_frame(16'h0000, 16'hFFFF, 24);  // R4 mid-scale, R3 extra slots
    send_frame(16'h1234, 16'hABCD, 32);  // R3 64fs
    send_frame(16'h8001, 16'h7FFE, 32);  // R2 routing
    for (int k = 0; k < 6; k++) begin
      int slots;
      slots = (k % 3 == 0) ? 16 : ((k % 3 == 1) ? 20 : 32);
      send_frame(16'($urandom), 16'($urandom), slots); // R1 random patterns
    end
    final_drain("R5 pairs missing (phase A)");

    // phase B: reset with channel clock high, partial left, orphan right (R7, R9)
    do_reset(1'b1);
    for (int i = 0; i < 10; i++) send_bit(1'($urandom));
    send_half(1'b0, 16'h5555, 16);       // R7 orphan right, must not appear
    send_frame(16'hAAAA, 16'h0F0F, 16);
    send_frame(16'h0001, 16'hFFFE, 32);
    send_frame(16'h8000, 16'h7FFF, 24);  // R4 swapped extremes
    final_drain("R5/R7 pairs missing (phase B)");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule